// File: doc/BRIEF.md
# Parallel NAND Read Responder

This block answers the device side of a parallel NAND-style bus for two chips at once, and serves only reads. A host selects a chip with one of two active-low chip enables. It writes command bytes while the command latch enable is high and address bytes while the address latch enable is high. It then pulses the read strobe once for each byte it wants. Each chip decodes commands into one of three read modes, builds a linear byte pointer from three address bytes, and returns the byte at that pointer on every read strobe. After each byte the pointer moves forward by one.

The page layout is not binary. A page is 528 bytes. The read mode sets where the column starts inside the page: at offset 0, 256 or 512. The second address byte is the high byte of the page number and the third is the low byte. Each chip's storage is a byte array of `MEM_BYTES` entries, and that size need not be a power of two. Every pointer calculation is reduced modulo the array size. A side load port writes bytes into either chip's array, and the whole array returns to the erased value 0xFF on reset. Write strobes and read strobes are sampled on the system clock. A byte is accepted on the clock where a strobe is seen to rise.

Top module: `nand_read_responder`

## Requirements
- R1: After reset `dq_oe` is 0, `rdy` is 2'b00, `err` is 2'b00, and every stored byte reads as 0xFF.
- R2: `ce1_n` low selects chip 0 whatever the value of `ce2_n`. Otherwise `ce2_n` low selects chip 1. With both high, bus activity changes no chip state and `dq_oe` stays 0.
- R3: When a chip is selected and both `re_n` and `we_n` are high, `dq_oe` is 0 and that chip's `rdy` bit (bit 0 for chip 0, bit 1 for chip 1) goes to 1 on the next clock and stays 1.
- R4: A byte taken on a rising `we_n` with `cle` high is a command. 0x00, 0x01 and 0x50 select read modes A, B and C and clear the address cycle count. 0xFF puts the chip into idle.
- R5: The first address byte sets the pointer to byte + 0 in mode A, byte + 256 in mode B and byte + 512 in mode C, modulo `MEM_BYTES`.
- R6: The second address byte adds byte × 135168 (528 × 256) to the pointer and the third adds byte × 528, each modulo `MEM_BYTES`.
- R7: While `re_n` is low on a selected chip with `cle` and `ale` both low, `dq_oe` is 1 and `dq_out` shows the byte at that chip's pointer. The pointer advances by one on the clock where `re_n` is seen to rise. With a latch enable high there is no drive and no advance.
- R8: Advancing from pointer `MEM_BYTES`-1 gives pointer 0.
- R9: An unknown command, a fourth address byte, or an address byte while idle sets that chip's sticky `err` bit. It leaves the mode and the pointer as they were.
- R10: Each chip keeps its own mode, pointer and address cycle count, and traffic to one chip leaves the other's unchanged.
- R11: When `cle` and `ale` are both high on a rising `we_n`, the byte is taken as a command.
- R12: When `ld_en` is high, `ld_data` is written on the clock edge to byte `ld_addr` of chip `ld_chip` (0 or 1). A read strobe that is low over that edge on the same byte shows the new value afterwards and still advances the pointer only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip 0 enable, active low, has priority |
| ce2_n | input | 1 | Chip 1 enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dq_in | input | 8 | Data bus from the host |
| dq_out | output | 8 | Data bus to the host, 0 when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| rdy | output | 2 | Per-chip ready line |
| err | output | 2 | Per-chip sticky protocol error |
| ld_en | input | 1 | Side load write enable |
| ld_chip | input | 1 | Side load chip index |
| ld_addr | input | PW | Side load byte address |
| ld_data | input | 8 | Side load byte |

## Verification
The side load port and a read strobe can act in the same clock. A load can write the very byte that a held-low read strobe is presenting. The bench provokes this by lowering `re_n` and starting a load to the current pointer address together. It confirms that the old byte is shown before the edge and the new byte after it. Once the strobe is released, the next read must return the following address, which shows that the coincidence neither skipped nor repeated a pointer step.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int NCHIP = 2;

  localparam logic [31:0] PAGE_BYTES     = 32'd528;
  localparam logic [31:0] PAGE_HI_STRIDE = PAGE_BYTES * 32'd256;
  localparam logic [31:0] COL_OFS_B      = 32'd256;
  localparam logic [31:0] COL_OFS_C      = 32'd512;

  localparam logic [7:0] CMD_IDLE = 8'hFF;
  localparam logic [7:0] CMD_RD_A = 8'h00;
  localparam logic [7:0] CMD_RD_B = 8'h01;
  localparam logic [7:0] CMD_RD_C = 8'h50;

  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_A,
    MODE_B,
    MODE_C
  } rd_mode_e;
endpackage

// File: rtl/nand_rd_decode.sv
module nand_rd_decode
  import nand_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             re_n,
  input  logic             we_n,
  output logic [NCHIP-1:0] cmd_ev,
  output logic [NCHIP-1:0] addr_ev,
  output logic [NCHIP-1:0] step_ev,
  output logic [NCHIP-1:0] rdy_set,
  output logic             sel,
  output logic             drive
);
  logic we_q, re_q, we_d, re_d;
  logic sel_ok, we_rise, re_rise;
  logic [NCHIP-1:0] chip_hot;

  always_comb begin
    we_d = we_n;
    re_d = re_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_d;
      re_q <= re_d;
    end
  end

  always_comb begin
    sel_ok   = ~(ce1_n & ce2_n);
    sel      = ce1_n;
    chip_hot = sel_ok ? (sel ? 2'b10 : 2'b01) : 2'b00;
    we_rise  = ~we_q & we_n;
    re_rise  = ~re_q & re_n;
    cmd_ev   = chip_hot & {NCHIP{we_rise & cle}};
    addr_ev  = chip_hot & {NCHIP{we_rise & ~cle & ale}};
    step_ev  = chip_hot & {NCHIP{re_rise & ~cle & ~ale}};
    rdy_set  = chip_hot & {NCHIP{re_n & we_n}};
    drive    = sel_ok & ~re_n & ~cle & ~ale;
  end

  // R11: command, address and step never hit in the same clock
  a_r11_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ev, addr_ev, step_ev}));

  // R2: chip 0 wins when both enables are low
  a_r2_ce1_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && !ce2_n) |-> (cmd_ev[1] == 1'b0 && addr_ev[1] == 1'b0 && step_ev[1] == 1'b0));
endmodule

// File: rtl/nand_rd_store.sv
module nand_rd_store
  import nand_rd_pkg::*;
#(
  parameter int MEM_BYTES = 1000,
  parameter int PW        = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic                       ld_chip,
  input  logic [PW-1:0]              ld_addr,
  input  logic [7:0]                 ld_data,
  input  logic [NCHIP-1:0][PW-1:0]   rd_addr,
  output logic [NCHIP-1:0][7:0]      rd_data
);
  logic [7:0] mem [NCHIP][MEM_BYTES];
  logic       wr_ok;

  always_comb wr_ok = ld_en && (int'(ld_addr) < MEM_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHIP; c++)
        for (int a = 0; a < MEM_BYTES; a++)
          mem[c][a] <= ERASED;
    end else if (wr_ok) begin
      mem[ld_chip][ld_addr] <= ld_data;
    end
  end

  for (genvar c = 0; c < NCHIP; c++) begin : g_rd
    assign rd_data[c] = mem[c][rd_addr[c]];
  end
endmodule

// File: rtl/nand_rd_chan.sv
module nand_rd_chan
  import nand_rd_pkg::*;
#(
  parameter int MEM_BYTES = 1000,
  parameter int PW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_ev,
  input  logic          addr_ev,
  input  logic          step_ev,
  input  logic          rdy_set,
  input  logic [7:0]    data,
  output logic [PW-1:0] ptr,
  output logic          err,
  output logic          rdy
);
  localparam logic [31:0]   MEM_W = 32'(MEM_BYTES);
  localparam logic [PW-1:0] LAST  = PW'(MEM_BYTES - 1);

  rd_mode_e      mode_q, mode_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d, rdy_q, rdy_d;
  logic [31:0]   ofs, col_w, hi_w, lo_w;

  always_comb begin
    case (mode_q)
      MODE_B:  ofs = COL_OFS_B;
      MODE_C:  ofs = COL_OFS_C;
      default: ofs = 32'd0;
    endcase
    col_w = (32'(data) + ofs) % MEM_W;
    hi_w  = (32'(ptr_q) + 32'(data) * PAGE_HI_STRIDE) % MEM_W;
    lo_w  = (32'(ptr_q) + 32'(data) * PAGE_BYTES) % MEM_W;
  end

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    err_d  = err_q;
    rdy_d  = rdy_q | rdy_set;
    if (cmd_ev) begin
      case (data)
        CMD_IDLE: mode_d = MODE_IDLE;
        CMD_RD_A: begin mode_d = MODE_A; cnt_d = 2'd0; end
        CMD_RD_B: begin mode_d = MODE_B; cnt_d = 2'd0; end
        CMD_RD_C: begin mode_d = MODE_C; cnt_d = 2'd0; end
        default:  err_d = 1'b1;
      endcase
    end else if (addr_ev) begin
      if (mode_q == MODE_IDLE || cnt_q == 2'd3) begin
        err_d = 1'b1;
      end else begin
        case (cnt_q)
          2'd0:    ptr_d = col_w[PW-1:0];
          2'd1:    ptr_d = hi_w[PW-1:0];
          default: ptr_d = lo_w[PW-1:0];
        endcase
        cnt_d = cnt_q + 2'd1;
      end
    end else if (step_ev) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      cnt_q  <= 2'd0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ptr = ptr_q;
  assign err = err_q;
  assign rdy = rdy_q;

  a_r4_mode_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && (data == CMD_RD_A || data == CMD_RD_B || data == CMD_RD_C))
      |=> (cnt_q == 2'd0 && mode_q != MODE_IDLE));

  a_r4_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && data == CMD_IDLE) |=> (mode_q == MODE_IDLE));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && ptr_q == LAST) |=> (ptr_q == '0));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r9_extra_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ev && cnt_q == 2'd3) |=> (err_q && ptr_q == $past(ptr_q)));

  a_r3_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> rdy_q);
endmodule

// File: rtl/nand_read_responder.sv
module nand_read_responder
  import nand_rd_pkg::*;
#(
  parameter int  MEM_BYTES = 1000,
  localparam int PW        = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             re_n,
  input  logic             we_n,
  input  logic [7:0]       dq_in,
  output logic [7:0]       dq_out,
  output logic             dq_oe,
  output logic [NCHIP-1:0] rdy,
  output logic [NCHIP-1:0] err,
  input  logic             ld_en,
  input  logic             ld_chip,
  input  logic [PW-1:0]    ld_addr,
  input  logic [7:0]       ld_data
);
  logic rst_q1, rst_q2;
  logic [NCHIP-1:0]         cmd_ev, addr_ev, step_ev, rdy_set;
  logic                     sel, drive;
  logic [NCHIP-1:0][PW-1:0] ptr_v;
  logic [NCHIP-1:0][7:0]    rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  nand_rd_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_q2),
    .ce1_n   (ce1_n),
    .ce2_n   (ce2_n),
    .cle     (cle),
    .ale     (ale),
    .re_n    (re_n),
    .we_n    (we_n),
    .cmd_ev  (cmd_ev),
    .addr_ev (addr_ev),
    .step_ev (step_ev),
    .rdy_set (rdy_set),
    .sel     (sel),
    .drive   (drive)
  );

  for (genvar c = 0; c < NCHIP; c++) begin : g_chan
    nand_rd_chan #(.MEM_BYTES(MEM_BYTES), .PW(PW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_q2),
      .cmd_ev  (cmd_ev[c]),
      .addr_ev (addr_ev[c]),
      .step_ev (step_ev[c]),
      .rdy_set (rdy_set[c]),
      .data    (dq_in),
      .ptr     (ptr_v[c]),
      .err     (err[c]),
      .rdy     (rdy[c])
    );
  end

  nand_rd_store #(.MEM_BYTES(MEM_BYTES), .PW(PW)) u_store (
    .clk     (clk),
    .rst_n   (rst_q2),
    .ld_en   (ld_en),
    .ld_chip (ld_chip),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .rd_addr (ptr_v),
    .rd_data (rd_data)
  );

  assign dq_oe  = drive;
  assign dq_out = drive ? rd_data[sel] : 8'h00;

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_q2)
    (ce1_n && ce2_n) |-> !dq_oe);

  a_r7_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_q2)
    dq_oe |-> (!re_n && !cle && !ale));
endmodule

// File: tb/sim_nand_read_responder.sv
module sim_nand_read_responder;
  localparam int MEM = 1000;
  localparam int PW  = $clog2(MEM);
  localparam int NV  = 31;
  // entry: {op[1:0] (0 cmd, 1 addr, 2 read), chip, byte}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {2'd0,1'b0,8'h00}, {2'd1,1'b0,8'h05}, {2'd1,1'b0,8'h01}, {2'd1,1'b0,8'h02},
    {2'd2,1'b0,8'h00}, {2'd2,1'b0,8'h00}, {2'd2,1'b0,8'h00},
    {2'd0,1'b1,8'h01}, {2'd1,1'b1,8'h10}, {2'd1,1'b1,8'h00}, {2'd1,1'b1,8'h00},
    {2'd2,1'b1,8'h00}, {2'd2,1'b1,8'h00},
    {2'd0,1'b0,8'h50}, {2'd1,1'b0,8'hF0}, {2'd1,1'b0,8'h03}, {2'd1,1'b0,8'h00},
    {2'd2,1'b0,8'h00},
    {2'd0,1'b1,8'h00}, {2'd1,1'b1,8'hE7}, {2'd1,1'b1,8'h00}, {2'd1,1'b1,8'h05},
    {2'd2,1'b1,8'h00}, {2'd2,1'b0,8'h00},
    {2'd0,1'b0,8'h01}, {2'd1,1'b0,8'hFF}, {2'd1,1'b0,8'h5F}, {2'd1,1'b0,8'h01},
    {2'd2,1'b0,8'h00}, {2'd2,1'b0,8'h00}, {2'd2,1'b0,8'h00}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ce1_n, ce2_n, cle, ale, re_n, we_n, dq_oe, ld_en, ld_chip;
  logic [7:0] dq_in, dq_out, ld_data;
  logic [1:0] rdy, err;
  logic [PW-1:0] ld_addr;

  nand_read_responder #(.MEM_BYTES(MEM)) u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .cle(cle), .ale(ale),
    .re_n(re_n), .we_n(we_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rdy(rdy), .err(err), .ld_en(ld_en), .ld_chip(ld_chip), .ld_addr(ld_addr),
    .ld_data(ld_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] bmem [2][MEM];
  int mmode [2];
  int mcnt [2];
  int mptr [2];

  function automatic logic [7:0] pat(int c, int a);
    return 8'((a * 37 + c * 101 + 11) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setsel(int s);
    ce1_n = !(s == 0 || s == 3);
    ce2_n = !(s == 1 || s == 3);
  endtask

  function automatic int chip_of(int s);
    if (s == 2) return -1;
    return (s == 1) ? 1 : 0;
  endfunction

  task automatic m_cmd(int c, logic [7:0] b);
    case (b)
      8'hFF: mmode[c] = 0;
      8'h00: begin mmode[c] = 1; mcnt[c] = 0; end
      8'h01: begin mmode[c] = 2; mcnt[c] = 0; end
      8'h50: begin mmode[c] = 3; mcnt[c] = 0; end
      default: ;
    endcase
  endtask

  task automatic m_addr(int c, logic [7:0] b);
    if (mmode[c] != 0 && mcnt[c] < 3) begin
      case (mcnt[c])
        0: mptr[c] = (int'(b) + (mmode[c] == 2 ? 256 : (mmode[c] == 3 ? 512 : 0))) % MEM;
        1: mptr[c] = (mptr[c] + int'(b) * 135168) % MEM;
        default: mptr[c] = (mptr[c] + int'(b) * 528) % MEM;
      endcase
      mcnt[c]++;
    end
  endtask

  task automatic bus_write(int s, bit c_le, bit a_le, logic [7:0] b);
    int c;
    c = chip_of(s);
    setsel(s); cle = c_le; ale = a_le; dq_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
    if (c >= 0) begin
      if (c_le) m_cmd(c, b);
      else if (a_le) m_addr(c, b);
    end
  endtask

  task automatic do_read(int s, string tag);
    int c;
    c = chip_of(s);
    setsel(s); cle = 1'b0; ale = 1'b0; re_n = 1'b0;
    @(negedge clk);
    chk({tag, " oe"}, int'(dq_oe), 1);
    chk({tag, " byte"}, int'(dq_out), int'(bmem[c][mptr[c]]));
    re_n = 1'b1;
    @(negedge clk);
    mptr[c] = (mptr[c] + 1) % MEM;
  endtask

  task automatic load_one(int c, int a, logic [7:0] b);
    ld_en = 1'b1; ld_chip = c[0]; ld_addr = PW'(a); ld_data = b;
    @(negedge clk);
    ld_en = 1'b0;
    bmem[c][a] = b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce1_n = 1'b1; ce2_n = 1'b1; cle = 1'b0; ale = 1'b0;
    re_n = 1'b1; we_n = 1'b1; dq_in = 8'h00;
    ld_en = 1'b0; ld_chip = 1'b0; ld_addr = '0; ld_data = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      mmode[c] = 0; mcnt[c] = 0; mptr[c] = 0;
      for (int a = 0; a < MEM; a++) bmem[c][a] = 8'hFF;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset dq_oe", int'(dq_oe), 0);
    chk("R1 reset rdy", int'(rdy), 0);
    chk("R1 reset err", int'(err), 0);

    for (int c = 0; c < 2; c++)
      for (int a = 0; a < MEM; a++) load_one(c, a, pat(c, a));

    // table: R4 R5 R6 R7 R8 R10 through modes, page strides and wrap
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][10:9])
        2'd0: bus_write(int'(VEC[i][8]), 1'b1, 1'b0, VEC[i][7:0]);
        2'd1: bus_write(int'(VEC[i][8]), 1'b0, 1'b1, VEC[i][7:0]);
        default: do_read(int'(VEC[i][8]), "R7 table read (R4 R5 R6 R8 R10)");
      endcase
    end

    // R2: no chip selected
    bus_write(2, 1'b1, 1'b0, 8'h00);
    bus_write(2, 1'b0, 1'b1, 8'h09);
    setsel(2); re_n = 1'b0;
    @(negedge clk);
    chk("R2 deselected bus not driven", int'(dq_oe), 0);
    re_n = 1'b1;
    @(negedge clk);
    do_read(0, "R2 pointer untouched while deselected");

    // R2: both enables low go to chip 0; R10 chip 1 unaffected
    bus_write(3, 1'b1, 1'b0, 8'h00);
    bus_write(3, 1'b0, 1'b1, 8'h21);
    bus_write(3, 1'b0, 1'b1, 8'h00);
    bus_write(3, 1'b0, 1'b1, 8'h00);
    do_read(3, "R2 both low selects chip 0");
    do_read(1, "R10 chip 1 pointer independent");

    // R7: address latch high during read strobe
    setsel(0); ale = 1'b1; re_n = 1'b0;
    @(negedge clk);
    chk("R7 no drive with ale high", int'(dq_oe), 0);
    re_n = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    do_read(0, "R7 no advance with ale high");

    // R11: both latch enables high is a command
    bus_write(1, 1'b1, 1'b0, 8'hFF);
    bus_write(1, 1'b1, 1'b1, 8'h00);
    bus_write(1, 1'b0, 1'b1, 8'h02);
    bus_write(1, 1'b0, 1'b1, 8'h00);
    bus_write(1, 1'b0, 1'b1, 8'h00);
    chk("R11 no error from cle+ale command", int'(err), 0);
    do_read(1, "R11 cle priority read");

    // R12: load and read strobe on the same byte in one clock
    setsel(1); re_n = 1'b0;
    ld_en = 1'b1; ld_chip = 1'b1; ld_addr = PW'(mptr[1]); ld_data = 8'hA5;
    #2;
    chk("R12 old byte before load edge", int'(dq_out), int'(bmem[1][mptr[1]]));
    @(negedge clk);
    chk("R12 new byte after load edge", int'(dq_out), 8'hA5);
    ld_en = 1'b0; re_n = 1'b1;
    @(negedge clk);
    bmem[1][mptr[1]] = 8'hA5;
    mptr[1] = (mptr[1] + 1) % MEM;
    do_read(1, "R12 pointer advanced once");

    // R9: address while idle, then unknown command
    bus_write(1, 1'b1, 1'b0, 8'hFF);
    bus_write(1, 1'b0, 1'b1, 8'h07);
    chk("R9 idle address flags chip 1", int'(err), 2);
    do_read(1, "R9 pointer kept after idle address");
    bus_write(0, 1'b1, 1'b0, 8'h90);
    chk("R9 unknown command flags chip 0", int'(err), 3);
    do_read(0, "R9 mode kept after unknown command");

    // R1 again, then R3 ready
    do_reset();
    chk("R1 second reset err", int'(err), 0);
    chk("R1 second reset rdy", int'(rdy), 0);
    setsel(1);
    @(negedge clk);
    chk("R3 rdy set for chip 1", int'(rdy), 2);
    chk("R3 bus released", int'(dq_oe), 0);
    setsel(2);
    @(negedge clk);
    chk("R3 rdy stays high", int'(rdy), 2);
    do_read(0, "R1 erased byte reads FF");

    // R9: fourth address byte
    bus_write(0, 1'b1, 1'b0, 8'h00);
    bus_write(0, 1'b0, 1'b1, 8'h04);
    bus_write(0, 1'b0, 1'b1, 8'h00);
    bus_write(0, 1'b0, 1'b1, 8'h00);
    load_one(0, 4, 8'h3C);
    load_one(0, 532, 8'h77);
    bus_write(0, 1'b0, 1'b1, 8'h01);
    chk("R9 fourth address flags chip 0", int'(err), 1);
    do_read(0, "R9 pointer kept after fourth address byte");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule